// File: doc/BRIEF.md
# Read-Data Parity Error Reporter

This block sits on one side of a bus-to-bus bridge, on the interface where the bridge acts as initiator and receives read data from a target. It watches each completed read data phase, which is a clock edge where both ready strobes are low while a read is in progress. It captures the address/data and byte-enable lines on that edge and checks them against the parity bit, which arrives one clock later. When the check fails it records the event in two sticky status bits. If the interface's parity-error-response enable is set, it also drives the bus error line low in the cycle that other agents sample two clocks after the transfer.

Each received word travels toward the opposite bus exactly as it arrived: data, byte enables and parity. A corrupt parity bit is therefore handed on to the requesting initiator and is never repaired. The transaction itself is never aborted or retried because of a parity failure. An error indication raised by the far-side initiator against the returned data is accepted but changes nothing in this block. Software clears the status bits by writing ones to them.

Top module: `rdpar_reporter`

## Requirements
- R1: After reset, perr_oe_o is 0, perr_n_o is 1, stat_o is 2'b00 and fwd_valid_o is 0.
- R2: A data phase is checked when, at a rising edge, irdy_n_i and trdy_n_i are both 0 and rd_phase_i is 1. Parity is even: the XOR of the captured ad_i, the captured cbe_n_i and par_i, with par_i sampled at the next rising edge, must be 0.
- R3: When the check fails and perr_resp_en_i is 1 at the parity edge, perr_n_o is 0 and perr_oe_o is 1 for exactly the one clock that follows the parity edge. Agents therefore sample the error low at the second edge after the transfer.
- R4: After its last low cycle, perr_n_o is driven 1 with perr_oe_o 1 for one clock, and then perr_oe_o returns to 0. Failing phases on consecutive edges keep perr_n_o low without a gap.
- R5: With perr_resp_en_i 0 at the parity edge, a failing phase leaves perr_oe_o at 0.
- R6: stat_o[0] (detected parity error) is set by every failing phase, whatever the value of perr_resp_en_i.
- R7: stat_o[1] (data parity reported) is set by a failing phase only when perr_resp_en_i is 1.
- R8: Both status bits are sticky. A write with stat_wr_i 1 clears each bit whose stat_wdata_i bit is 1 and leaves the others unchanged. A set on the same edge overrides the clear.
- R9: For one clock after the parity edge, fwd_valid_o is 1 and fwd_ad_o, fwd_cbe_n_o and fwd_par_o carry the captured data and byte enables and the sampled parity, unchanged even when the parity is wrong.
- R10: peer_perr_n_i has no effect on perr_n_o, perr_oe_o or stat_o.
- R11: Edges where only one strobe is low, or where rd_phase_i is 0, start no check. They leave fwd_valid_o, perr_oe_o and stat_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | AD_W | Address/data lines |
| cbe_n_i | input | BE_W | Command/byte-enable lines |
| par_i | input | 1 | Parity bit, valid one clock after its data phase |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| rd_phase_i | input | 1 | High while this interface is receiving read data |
| perr_resp_en_i | input | 1 | Parity-error-response enable for this interface |
| peer_perr_n_i | input | 1 | Error line from the far-side initiator (ignored) |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 2 | Write-one-to-clear mask, bit 0 detected, bit 1 reported |
| perr_n_o | output | 1 | Error line value, active low |
| perr_oe_o | output | 1 | Error line drive enable |
| stat_o | output | 2 | Bit 0 detected parity error, bit 1 data parity reported |
| fwd_valid_o | output | 1 | Forwarded word valid |
| fwd_ad_o | output | AD_W | Forwarded data |
| fwd_cbe_n_o | output | BE_W | Forwarded byte enables |
| fwd_par_o | output | 1 | Forwarded parity, as received |

## Verification
The assertions assume a few things about the inputs. The strobes and rd_phase_i are free of X once reset is released. par_i is valid at the edge after each checked phase. perr_resp_en_i does not change between a transfer edge and its parity edge. The stimulus tasks hold these conditions by changing inputs only on falling edges and by keeping the enable constant across each phase. A status write lands on the same edge as a parity failure in exactly one scenario, which is used to show that the set overrides the clear. Bursts of failing phases on consecutive edges check that the error line stays low continuously and that its release cycle comes only after the last failure.

// File: rtl/rdpar_pkg.sv
package rdpar_pkg;
   localparam int STAT_W   = 2;
   localparam int STAT_DET = 0;
   localparam int STAT_DPD = 1;

   typedef struct packed {
      logic dpd;
      logic det;
   } rdpar_stat_t;
endpackage

// File: rtl/rdpar_parity_tree.sv
module rdpar_parity_tree #(
   parameter int AD_W    = 32,
   parameter int BE_W    = 4,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic [AD_W-1:0] ad,
   input  logic [BE_W-1:0] cbe_n,
   input  logic            par,
   output logic            bad
);
   localparam int LANE_W = AD_W / BE_W;

   if (AD_W % BE_W != 0) begin : g_lane_bad
      $error("AD_W must be a multiple of BE_W");
   end

   logic [BE_W-1:0] lane_x;

   for (genvar g = 0; g < BE_W; g++) begin : g_lane
      assign lane_x[g] = (^ad[g*LANE_W +: LANE_W]) ^ cbe_n[g];
   end

   logic sum_x;
   assign sum_x = (^lane_x) ^ par;

   if (ODD_PAR) begin : g_odd
      assign bad = ~sum_x;
   end else begin : g_even
      assign bad = sum_x;
   end
endmodule

// File: rtl/rdpar_capture.sv
module rdpar_capture #(
   parameter int AD_W = 32,
   parameter int BE_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AD_W-1:0] ad_i,
   input  logic [BE_W-1:0] cbe_n_i,
   input  logic            par_i,
   input  logic            irdy_n_i,
   input  logic            trdy_n_i,
   input  logic            rd_phase_i,
   output logic            chk_valid,
   output logic [AD_W-1:0] ad_q,
   output logic [BE_W-1:0] cbe_q,
   output logic            fwd_valid_o,
   output logic [AD_W-1:0] fwd_ad_o,
   output logic [BE_W-1:0] fwd_cbe_n_o,
   output logic            fwd_par_o
);
   logic xfer;
   assign xfer = !irdy_n_i && !trdy_n_i && rd_phase_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_valid <= 1'b0;
         ad_q      <= '0;
         cbe_q     <= '0;
      end else begin
         chk_valid <= xfer;
         if (xfer) begin
            ad_q  <= ad_i;
            cbe_q <= cbe_n_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid_o <= 1'b0;
         fwd_ad_o    <= '0;
         fwd_cbe_n_o <= '0;
         fwd_par_o   <= 1'b0;
      end else begin
         fwd_valid_o <= chk_valid;
         if (chk_valid) begin
            fwd_ad_o    <= ad_q;
            fwd_cbe_n_o <= cbe_q;
            fwd_par_o   <= par_i;
         end
      end
   end

   // R11
   no_check_without_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irdy_n_i || trdy_n_i || !rd_phase_i) |=> !chk_valid);

   // R9
   fwd_follows_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> (fwd_valid_o && fwd_ad_o == $past(ad_q) && fwd_par_o == $past(par_i)));
endmodule

// File: rtl/rdpar_perr_drv.sv
module rdpar_perr_drv #(
   parameter bit RELEASE_CYC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic perr_n_o,
   output logic perr_oe_o
);
   logic lo_q;
   logic oe_q;
   logic oe_next;

   if (RELEASE_CYC) begin : g_rel
      assign oe_next = fire || lo_q;
   end else begin : g_norel
      assign oe_next = fire;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         lo_q <= fire;
         oe_q <= oe_next;
      end
   end

   assign perr_n_o  = ~lo_q;
   assign perr_oe_o = oe_q;

   // R4
   low_implies_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> perr_oe_o);

   if (RELEASE_CYC) begin : g_rel_chk
      // R4
      release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(perr_n_o) |-> perr_oe_o);
      // R4
      release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (perr_oe_o && perr_n_o && !fire) |=> !perr_oe_o);
   end
endmodule

// File: rtl/rdpar_status.sv
module rdpar_status
   import rdpar_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_det,
   input  logic              set_dpd,
   input  logic              wr,
   input  logic [STAT_W-1:0] wdata,
   output rdpar_stat_t       stat
);
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic [STAT_W-1:0] cur;
   logic [STAT_W-1:0] nxt;

   assign set_vec[STAT_DET] = set_det;
   assign set_vec[STAT_DPD] = set_dpd;
   assign clr_vec           = wr ? wdata : '0;

   for (genvar g = 0; g < STAT_W; g++) begin : g_bit
      assign nxt[g] = set_vec[g] || (cur[g] && !clr_vec[g]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= '0;
      else        cur <= nxt;
   end

   assign stat = rdpar_stat_t'(cur);

   // R6
   det_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_det |=> stat.det);
   // R8
   det_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[STAT_DET] && !set_det) |=> !stat.det);
   // R7
   dpd_only_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat.dpd) |-> $past(set_dpd));
   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && stat.det) |=> stat.det);
endmodule

// File: rtl/rdpar_reporter.sv
module rdpar_reporter
   import rdpar_pkg::*;
#(
   parameter int AD_W        = 32,
   parameter int BE_W        = 4,
   parameter bit ODD_PAR     = 1'b0,
   parameter bit RELEASE_CYC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AD_W-1:0]   ad_i,
   input  logic [BE_W-1:0]   cbe_n_i,
   input  logic              par_i,
   input  logic              irdy_n_i,
   input  logic              trdy_n_i,
   input  logic              rd_phase_i,
   input  logic              perr_resp_en_i,
   input  logic              peer_perr_n_i,
   input  logic              stat_wr_i,
   input  logic [STAT_W-1:0] stat_wdata_i,
   output logic              perr_n_o,
   output logic              perr_oe_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              fwd_valid_o,
   output logic [AD_W-1:0]   fwd_ad_o,
   output logic [BE_W-1:0]   fwd_cbe_n_o,
   output logic              fwd_par_o
);
   if (AD_W < 8 || BE_W < 1) begin : g_size_bad
      $error("AD_W must be at least 8 and BE_W at least 1");
   end

   logic            chk_valid;
   logic [AD_W-1:0] ad_q;
   logic [BE_W-1:0] cbe_q;
   logic            par_bad;
   logic            chk_err;
   logic            fire;
   rdpar_stat_t     stat;

   rdpar_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .ad_i        (ad_i),
      .cbe_n_i     (cbe_n_i),
      .par_i       (par_i),
      .irdy_n_i    (irdy_n_i),
      .trdy_n_i    (trdy_n_i),
      .rd_phase_i  (rd_phase_i),
      .chk_valid   (chk_valid),
      .ad_q        (ad_q),
      .cbe_q       (cbe_q),
      .fwd_valid_o (fwd_valid_o),
      .fwd_ad_o    (fwd_ad_o),
      .fwd_cbe_n_o (fwd_cbe_n_o),
      .fwd_par_o   (fwd_par_o)
   );

   rdpar_parity_tree #(.AD_W(AD_W), .BE_W(BE_W), .ODD_PAR(ODD_PAR)) u_tree (
      .ad    (ad_q),
      .cbe_n (cbe_q),
      .par   (par_i),
      .bad   (par_bad)
   );

   assign chk_err = chk_valid && par_bad;
   assign fire    = chk_err && perr_resp_en_i;

   rdpar_perr_drv #(.RELEASE_CYC(RELEASE_CYC)) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .perr_n_o  (perr_n_o),
      .perr_oe_o (perr_oe_o)
   );

   rdpar_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_det (chk_err),
      .set_dpd (fire),
      .wr      (stat_wr_i),
      .wdata   (stat_wdata_i),
      .stat    (stat)
   );

   assign stat_o = stat;

   // R3
   perr_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(perr_n_o) |-> $past(chk_valid));
   // R5
   no_perr_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !perr_resp_en_i) |=> perr_n_o);
   // R10
   peer_perr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!peer_perr_n_i && !chk_valid && !stat_wr_i) |=> $stable(stat_o));
   // R9
   fwd_only_after_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid_o |-> $past(chk_valid));
endmodule

// File: tb/rdpar_reporter_tb.sv
module rdpar_reporter_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe = '0;
   logic        par = 1'b0;
   logic        irdy_n = 1'b1;
   logic        trdy_n = 1'b1;
   logic        rd = 1'b0;
   logic        en = 1'b1;
   logic        peer_n = 1'b1;
   logic        swr = 1'b0;
   logic [1:0]  swd = '0;
   logic        perr_n, perr_oe, fwd_valid, fwd_par;
   logic [1:0]  stat;
   logic [31:0] fwd_ad;
   logic [3:0]  fwd_cbe;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rdpar_reporter u_dut (
      .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe), .par_i(par),
      .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .rd_phase_i(rd),
      .perr_resp_en_i(en), .peer_perr_n_i(peer_n),
      .stat_wr_i(swr), .stat_wdata_i(swd),
      .perr_n_o(perr_n), .perr_oe_o(perr_oe), .stat_o(stat),
      .fwd_valid_o(fwd_valid), .fwd_ad_o(fwd_ad), .fwd_cbe_n_o(fwd_cbe),
      .fwd_par_o(fwd_par));

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic good_par(input logic [31:0] a, input logic [3:0] c);
      return ^{a, c};
   endfunction

   task automatic clear_all();
      @(negedge clk); swr = 1'b1; swd = 2'b11;
      @(negedge clk); swr = 1'b0; swd = 2'b00;
   endtask

   // one read phase; samples the three cycles after the parity edge
   task automatic one_phase(input string req, input logic [31:0] a, input logic [3:0] c,
                            input bit bad, input bit ena);
      logic p;
      p = good_par(a, c) ^ bad;
      en = ena;
      @(negedge clk); ad = a; cbe = c; irdy_n = 0; trdy_n = 0; rd = 1; par = 1'b0;
      @(negedge clk); irdy_n = 1; trdy_n = 1; ad = ~a; cbe = ~c; par = p;
      @(negedge clk);
      check(req, "perr_n low cycle", perr_n, !(bad && ena));
      check(req, "perr_oe low cycle", perr_oe, bad && ena);
      check("R9", "fwd_valid", fwd_valid, 1);
      check("R9", "fwd_ad", fwd_ad, a);
      check("R9", "fwd_cbe", fwd_cbe, c);
      check("R9", "fwd_par", fwd_par, p);
      @(negedge clk);
      check("R4", "perr_n release", perr_n, 1);
      check("R4", "perr_oe release", perr_oe, bad && ena);
      check("R9", "fwd_valid drop", fwd_valid, 0);
      @(negedge clk);
      check("R4", "perr_oe off", perr_oe, 0);
   endtask

   task automatic t_reset();
      check("R1", "perr_oe", perr_oe, 0);
      check("R1", "perr_n", perr_n, 1);
      check("R1", "stat", stat, 2'b00);
      check("R1", "fwd_valid", fwd_valid, 0);
   endtask

   task automatic t_good();
      one_phase("R2", 32'h1234_5678, 4'h0, 0, 1);
      one_phase("R2", 32'hFFFF_0001, 4'hA, 0, 1);
      check("R2", "stat after good", stat, 2'b00);
   endtask

   task automatic t_bad_enabled();
      one_phase("R3", 32'hDEAD_BEEF, 4'h3, 1, 1);
      check("R6", "det set", stat[0], 1);
      check("R7", "dpd set", stat[1], 1);
      clear_all();
      check("R8", "cleared", stat, 2'b00);
   endtask

   task automatic t_bad_disabled();
      one_phase("R5", 32'h0F0F_1111, 4'h5, 1, 0);
      check("R6", "det set no enable", stat[0], 1);
      check("R7", "dpd stays clear", stat[1], 0);
      clear_all();
   endtask

   task automatic t_w1c();
      one_phase("R8", 32'h8000_0000, 4'hF, 1, 1);
      @(negedge clk); swr = 1; swd = 2'b01;
      @(negedge clk); swr = 0; swd = 2'b00;
      check("R8", "clear det only", stat, 2'b10);
      @(negedge clk); swr = 1; swd = 2'b00;
      @(negedge clk); swr = 0;
      check("R8", "zero write keeps", stat, 2'b10);
      @(negedge clk); swr = 1; swd = 2'b10;
      @(negedge clk); swr = 0; swd = 2'b00;
      check("R8", "clear dpd", stat, 2'b00);
   endtask

   task automatic t_set_wins();
      logic [31:0] a;
      a = 32'h5555_AAAA;
      en = 1;
      @(negedge clk); ad = a; cbe = 4'h1; irdy_n = 0; trdy_n = 0; rd = 1;
      @(negedge clk); irdy_n = 1; trdy_n = 1; par = ~good_par(a, 4'h1); swr = 1; swd = 2'b11;
      @(negedge clk); swr = 0; swd = 2'b00;
      check("R8", "set beats clear", stat, 2'b11);
      @(negedge clk); @(negedge clk);
      clear_all();
   endtask

   task automatic t_burst();
      en = 1;
      @(negedge clk); ad = 32'h1; cbe = 4'h0; irdy_n = 0; trdy_n = 0; rd = 1;
      @(negedge clk); par = ~good_par(32'h1, 4'h0); ad = 32'h3; cbe = 4'h0;
      @(negedge clk); irdy_n = 1; trdy_n = 1; par = ~good_par(32'h3, 4'h0);
      check("R3", "burst first low", perr_n, 0);
      @(negedge clk);
      check("R4", "burst second low", perr_n, 0);
      check("R4", "burst oe", perr_oe, 1);
      @(negedge clk);
      check("R4", "burst release high", {perr_oe, perr_n}, 2'b11);
      @(negedge clk);
      check("R4", "burst off", perr_oe, 0);
      clear_all();
   endtask

   task automatic t_peer();
      peer_n = 0;
      one_phase("R10", 32'hCAFE_0000, 4'h7, 0, 1);
      check("R10", "stat with peer error", stat, 2'b00);
      @(negedge clk);
      check("R10", "no drive with peer error", perr_oe, 0);
      peer_n = 1;
   endtask

   task automatic t_not_read();
      en = 1;
      @(negedge clk); ad = 32'h7; cbe = 4'h0; irdy_n = 0; trdy_n = 0; rd = 0;
      @(negedge clk); irdy_n = 1; trdy_n = 1; par = ~good_par(32'h7, 4'h0);
      @(negedge clk);
      check("R11", "write phase no fwd", fwd_valid, 0);
      check("R11", "write phase no perr", perr_oe, 0);
      @(negedge clk); ad = 32'h7; irdy_n = 0; trdy_n = 1; rd = 1;
      @(negedge clk); irdy_n = 1; par = ~good_par(32'h7, 4'h0);
      @(negedge clk);
      check("R11", "single strobe no fwd", fwd_valid, 0);
      check("R11", "single strobe stat", stat, 2'b00);
      rd = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_good();
      t_bad_enabled();
      t_bad_disabled();
      t_w1c();
      t_set_wins();
      t_burst();
      t_peer();
      t_not_read();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule